// File: doc/BRIEF.md
# Configurable Sum-of-Products Macrocell

This block is one logic cell of a programmable function block. A small plane of product terms is built from the data inputs and from the cell's own registered value. Each term takes its literals, true or complemented, from a configuration vector. The terms are ORed into a single sum. A polarity bit can then invert that sum.

The polarity result feeds a D flip-flop, which has a synchronous clear and a clock enable. A select bit chooses whether the pin carries the registered value or the combinational one. A separate enable bit decides whether the pin drives or is released for use as an input.

The pin is modelled as three separate signals: a data out, a drive enable and a data in. The value arriving on the pin is always returned on a feedback output. The registered value is returned as well, and it also feeds one column of the term plane. A larger wrapper would instantiate sixteen of these cells per function block and route their feedback outputs.

Top module: `cpld_macrocell`

## Requirements
- R1: Term t is the AND of every literal whose link bit is set. Column c has its true link at bit `(t*NCOL+c)*2` of `cfg_and` and its complement link at the bit one above it. Columns 0..N_IN-1 are `din` and column NCOL-1 (NCOL = N_IN+1) is the registered value. A term with no links set is 1. A term with both links of any one column set is 0.
- R2: The sum is the OR of all N_TERMS product terms.
- R3: When `cfg_inv` is 1 the sum is inverted, and the inverted value reaches both the register input and the combinational pin path. When `cfg_inv` is 0 the sum passes through unchanged.
- R4: A clock edge with `rst` high sets the register to 0, whatever `ce` is.
- R5: A clock edge with `rst` low and `ce` low leaves the register unchanged.
- R6: A clock edge with `rst` low and `ce` high loads the polarity result into the register.
- R7: With `cfg_comb` = 1, `pin_o` equals the polarity result in the same cycle. With `cfg_comb` = 0, `pin_o` equals the registered value.
- R8: `pin_oe` equals `cfg_oe`. `pin_fb` always equals `pin_i`, whether or not the pin is driven.
- R9: `q_fb` shows the registered value. A term that uses the complement of the register column makes the register toggle on each enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous clear of the register, active high |
| ce | input | 1 | Register clock enable |
| din | input | N_IN | Data inputs to the term plane |
| cfg_and | input | N_TERMS*2*NCOL | Literal link bits of the term plane |
| cfg_inv | input | 1 | Polarity invert select |
| cfg_comb | input | 1 | 1 = combinational pin path, 0 = registered |
| cfg_oe | input | 1 | Pin drive enable select |
| pin_i | input | 1 | Value arriving on the pin |
| pin_o | output | 1 | Value to drive on the pin |
| pin_oe | output | 1 | Pin driver enable |
| pin_fb | output | 1 | Pin input feedback |
| q_fb | output | 1 | Registered value feedback |

## Verification
The hardest situation to reach from the ports is the register feeding back through its own term, because only a configuration that suppresses every other term exposes it. The stimulus builds such a configuration directly: it poisons the other terms with both literals of one column and links the complement of the register column into a single term. It then checks that the register toggles, and that it holds while the enable is low. Random configurations use sparse link densities, so that the sum takes both values often. Directed cases cover the constant-one empty term and the always-zero poisoned term.

// File: rtl/mc_pkg.sv
package mc_pkg;
    // Register state of the macrocell
    typedef struct packed {
        logic q;
    } mc_state_t;

    // Index of the true-literal link of term t, column c
    function automatic int unsigned mc_link_idx(int unsigned t, int unsigned c, int unsigned ncol);
        return (t * ncol + c) * 2;
    endfunction
endpackage

// File: rtl/mc_and_plane.sv
module mc_and_plane #(
    parameter int unsigned N_COL   = 9,
    parameter int unsigned N_TERMS = 8,
    localparam int unsigned LINK_W = N_TERMS * 2 * N_COL
) (
    input  logic [N_COL-1:0]   col_i,
    input  logic [LINK_W-1:0]  link_i,
    output logic [N_TERMS-1:0] term_o
);
    for (genvar t = 0; t < N_TERMS; t++) begin : g_term
        logic [N_COL-1:0] lit_ok;
        for (genvar c = 0; c < N_COL; c++) begin : g_col
            localparam int unsigned BT = mc_pkg::mc_link_idx(t, c, N_COL);
            // A set link demands its literal; a clear link leaves the column free
            assign lit_ok[c] = (~link_i[BT] | col_i[c]) & (~link_i[BT+1] | ~col_i[c]);
        end
        assign term_o[t] = &lit_ok;
    end
endmodule

// File: rtl/mc_sum_pol.sv
module mc_sum_pol #(
    parameter int unsigned N_TERMS = 8
) (
    input  logic [N_TERMS-1:0] term_i,
    input  logic               inv_i,
    output logic               sum_o,
    output logic               pol_o
);
    always_comb begin
        sum_o = |term_i;
        pol_o = sum_o ^ inv_i;
    end
endmodule

// File: rtl/mc_out_stage.sv
module mc_out_stage
    import mc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  logic d_i,
    input  logic comb_sel_i,
    output logic q_o,
    output logic mux_o
);
    mc_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.q = 1'b0;
        end else if (ce) begin
            state_d.q = d_i;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign q_o   = state_q.q;
    assign mux_o = comb_sel_i ? d_i : state_q.q;
endmodule

// File: rtl/cpld_macrocell.sv
module cpld_macrocell #(
    parameter int unsigned N_IN    = 8,
    parameter int unsigned N_TERMS = 8,
    localparam int unsigned NCOL   = N_IN + 1,
    localparam int unsigned LINK_W = N_TERMS * 2 * NCOL
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic [N_IN-1:0]   din,
    input  logic [LINK_W-1:0] cfg_and,
    input  logic              cfg_inv,
    input  logic              cfg_comb,
    input  logic              cfg_oe,
    input  logic              pin_i,
    output logic              pin_o,
    output logic              pin_oe,
    output logic              pin_fb,
    output logic              q_fb
);
    logic [NCOL-1:0]    col_w;
    logic [N_TERMS-1:0] term_w;
    logic               sum_w;
    logic               pol_w;
    logic               q_w;

    // Register feedback occupies the top column of the plane
    assign col_w = {q_w, din};

    mc_and_plane #(.N_COL(NCOL), .N_TERMS(N_TERMS)) plane_i (
        .col_i  (col_w),
        .link_i (cfg_and),
        .term_o (term_w)
    );

    mc_sum_pol #(.N_TERMS(N_TERMS)) sum_i (
        .term_i (term_w),
        .inv_i  (cfg_inv),
        .sum_o  (sum_w),
        .pol_o  (pol_w)
    );

    mc_out_stage out_i (
        .clk        (clk),
        .rst        (rst),
        .ce         (ce),
        .d_i        (pol_w),
        .comb_sel_i (cfg_comb),
        .q_o        (q_w),
        .mux_o      (pin_o)
    );

    assign pin_oe = cfg_oe;
    assign pin_fb = pin_i;
    assign q_fb   = q_w;
endmodule

// File: rtl/mc_checker.sv
module mc_checker (
    input logic clk,
    input logic rst,
    input logic ce,
    input logic cfg_comb,
    input logic cfg_oe,
    input logic pin_i,
    input logic pin_o,
    input logic pin_oe,
    input logic pin_fb,
    input logic q_fb,
    input logic pol
);
    // R4: clear on reset, even with enable high
    a_r4_reset_clears: assert property (@(posedge clk) rst |=> (q_fb == 1'b0));

    // R5: hold when enable low
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (!ce) |=> (q_fb == $past(q_fb)));

    // R6: capture the polarity result
    a_r6_capture: assert property (@(posedge clk) disable iff (rst)
        ce |=> (q_fb == $past(pol)));

    // R7: registered path reaches the pin
    a_r7_reg_path: assert property (@(posedge clk) disable iff (rst)
        (!cfg_comb) |-> (pin_o == q_fb));

    // R7: combinational path reaches the pin
    a_r7_comb_path: assert property (@(posedge clk) disable iff (rst)
        cfg_comb |-> (pin_o == pol));

    // R8: pin direction and input feedback
    a_r8_pin_dir: assert property (@(posedge clk) disable iff (rst)
        (pin_oe == cfg_oe) && (pin_fb == pin_i));
endmodule

bind cpld_macrocell mc_checker chk_i (
    .clk      (clk),
    .rst      (rst),
    .ce       (ce),
    .cfg_comb (cfg_comb),
    .cfg_oe   (cfg_oe),
    .pin_i    (pin_i),
    .pin_o    (pin_o),
    .pin_oe   (pin_oe),
    .pin_fb   (pin_fb),
    .q_fb     (q_fb),
    .pol      (pol_w)
);

// File: tb/cpld_macrocell_tb_top.sv
module cpld_macrocell_tb_top;
    localparam int unsigned N_IN    = 8;
    localparam int unsigned N_TERMS = 8;
    localparam int unsigned NCOL    = N_IN + 1;
    localparam int unsigned LINK_W  = N_TERMS * 2 * NCOL;

    logic              clk = 1'b0;
    logic              rst, ce, cfg_inv, cfg_comb, cfg_oe, pin_i;
    logic [N_IN-1:0]   din;
    logic [LINK_W-1:0] cfg_and;
    logic              pin_o, pin_oe, pin_fb, q_fb;

    int   checks = 0;
    int   fails  = 0;
    logic q_exp  = 1'b0;

    always #10 clk = ~clk;

    cpld_macrocell #(.N_IN(N_IN), .N_TERMS(N_TERMS)) dut_i (
        .clk(clk), .rst(rst), .ce(ce), .din(din), .cfg_and(cfg_and),
        .cfg_inv(cfg_inv), .cfg_comb(cfg_comb), .cfg_oe(cfg_oe),
        .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe), .pin_fb(pin_fb), .q_fb(q_fb)
    );

    function automatic logic model_pol(logic [N_IN-1:0] d, logic q,
                                       logic [LINK_W-1:0] lk, logic inv);
        logic [NCOL-1:0] cols;
        logic s;
        cols = {q, d};
        s = 1'b0;
        for (int t = 0; t < N_TERMS; t++) begin
            logic p;
            p = 1'b1;
            for (int c = 0; c < NCOL; c++) begin
                if (lk[(t*NCOL+c)*2]   && !cols[c]) p = 1'b0;
                if (lk[(t*NCOL+c)*2+1] &&  cols[c]) p = 1'b0;
            end
            s = s | p;
        end
        return s ^ inv;
    endfunction

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Called just after a falling edge: check same-cycle outputs, then advance one clock
    task automatic step(string req);
        logic p;
        #1;
        p = model_pol(din, q_exp, cfg_and, cfg_inv);
        check({req, " pin_o"}, pin_o, cfg_comb ? p : q_exp);
        check("R8 pin_oe", pin_oe, cfg_oe);
        check("R8 pin_fb", pin_fb, pin_i);
        if (rst)     q_exp = 1'b0;
        else if (ce) q_exp = p;
        @(negedge clk);
        check({req, " q_fb"}, q_fb, q_exp);
    endtask

    function automatic logic [LINK_W-1:0] sparse_links(int unsigned shift);
        logic [LINK_W-1:0] v;
        for (int i = 0; i < LINK_W; i++) v[i] = (($urandom >> shift) & 3) == 0;
        return v;
    endfunction

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; ce = 1'b1; din = '0; cfg_and = '0;
        cfg_inv = 1'b0; cfg_comb = 1'b0; cfg_oe = 1'b0; pin_i = 1'b1;
        @(negedge clk);
        q_exp = 1'b0;
        // R4: reset with enable high and polarity result 1 (empty terms)
        check("R4 reset q", q_fb, 1'b0);
        step("R4");
        step("R4");

        // R1: empty terms are 1, sum 1, combinational path
        rst = 1'b0; ce = 1'b0; cfg_comb = 1'b1; cfg_oe = 1'b1;
        step("R1");
        // R3: invert
        cfg_inv = 1'b1;
        step("R3");
        // R1/R2: every term poisoned -> sum 0, inverted 1
        cfg_and = '1;
        step("R2");
        cfg_inv = 1'b0;
        step("R1");

        // R9/R6: toggle through the register column
        cfg_and = '0;
        for (int t = 1; t < N_TERMS; t++) begin
            cfg_and[(t*NCOL)*2]   = 1'b1;
            cfg_and[(t*NCOL)*2+1] = 1'b1;
        end
        cfg_and[(0*NCOL + N_IN)*2 + 1] = 1'b1;
        cfg_comb = 1'b0; ce = 1'b1;
        for (int i = 0; i < 4; i++) step("R9");
        // R5: hold
        ce = 1'b0;
        for (int i = 0; i < 3; i++) step("R5");
        // R4: reset wins over enable while toggling
        ce = 1'b1; rst = 1'b1;
        step("R4");
        rst = 1'b0;

        // R8: pin released, pin input still visible
        cfg_oe = 1'b0; pin_i = 1'b0;
        step("R8");
        pin_i = 1'b1;
        step("R8");

        // Random mix: R2 R3 R6 R7
        for (int i = 0; i < 600; i++) begin
            if (i % 25 == 0) cfg_and = sparse_links(i % 7);
            din      = N_IN'($urandom);
            ce       = ($urandom % 4) != 0;
            rst      = ($urandom % 40) == 0;
            cfg_inv  = $urandom % 2;
            cfg_comb = $urandom % 2;
            cfg_oe   = $urandom % 2;
            pin_i    = $urandom % 2;
            step("R7");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule